// File: doc/BRIEF.md
# Processor-Local Interrupt Gate

This block gathers a parameterised set of interrupt request lines (32 by default) into a pending-status register. It qualifies them with an enable-mask register and drives one interrupt request toward the processor core. Software reaches both registers through a small register port, which carries an address, a write strobe, write data and combinational read data. Software masks or unmasks a line by reading the mask, changing one bit and writing the whole word back. To find which line to service, it scans the raw status word for the lowest set bit.

A build-time parameter picks how the status register behaves. In level mode each status bit is a registered copy of its input and needs no acknowledge. In edge mode a rising edge on an input latches the bit, and writing a one to that bit position clears it. In legacy mode a high input level latches the bit, and writing a zero clears it.

Register map: address 0 is the mask, address 1 is the status, and every other address reads as zero and ignores writes.

Top module: `core_irq_pic`

## Requirements
- R1: After reset the mask reads 0, the status reads 0 and `coreIrq` is low.
- R2: A write to address 0 stores the full write word in the mask, and a read of address 0 returns it. A mask bit of 1 enables its line. The mask changes only on such a write.
- R3: `coreIrq` is a register that is high exactly one clock after some bit is set in both status and mask. It stays low while the mask is all zero.
- R4: A read of address 1 returns the raw status whatever the mask holds. Addresses 2 and 3 read as 0.
- R5: In edge mode a status bit is set at the clock edge where its input is high and was low at the previous edge. An input that stays high does not set the bit again after it has been cleared.
- R6: In edge mode, writing a 1 at a bit position of address 1 clears that status bit. Writing a 0 leaves the bit unchanged.
- R7: In edge mode, when a new edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: In legacy mode a high input sets its status bit, and the bit stays set after the input falls.
- R9: In legacy mode, writing a 0 at a bit position of address 1 clears that bit and writing a 1 leaves it unchanged. An input that is still high keeps its bit set through a clearing write.
- R10: In level mode each status bit equals its input as sampled at the previous clock edge, and writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_LINES | Interrupt request lines |
| regAddr | input | ADDR_W | Register address (0 mask, 1 status) |
| regWe | input | 1 | Register write strobe |
| regWdata | input | NUM_LINES | Register write data |
| regRdata | output | NUM_LINES | Register read data, combinational on address |
| coreIrq | output | 1 | Registered interrupt request to the core |

## Verification
On every cycle, the assertions check four things: the mask holds between writes, the interrupt output stays low after an all-zero mask, and each status bit sets and falls only in the way its mode allows (an edge or level latch, a clear of the right polarity, or a plain copy of the input). Some behaviours need chosen stimulus and are shown only by the bench's scenarios: exact readback values, the one-cycle delay of the interrupt after unmasking, the set-wins outcome when an edge and a clear land together, and the fact that a steady high input does not re-trigger in edge mode.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL  = 2'd0,
    MODE_EDGE   = 2'd1,
    MODE_LEGACY = 2'd2
  } statModeE;

  typedef struct packed {
    logic maskWr;
    logic statWr;
    logic rdMask;
    logic rdStat;
  } picStrobeT;

  localparam int unsigned MASK_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output picStrobeT         strobe
);
  logic hitMask;
  logic hitStat;

  always_comb begin
    hitMask       = (regAddr == ADDR_W'(MASK_ADDR));
    hitStat       = (regAddr == ADDR_W'(STAT_ADDR));
    strobe.maskWr = regWe && hitMask;
    strobe.statWr = regWe && hitStat;
    strobe.rdMask = hitMask;
    strobe.rdStat = hitStat;
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter statModeE    MODE      = MODE_EDGE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  picStrobeT            strobe,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  output logic                 coreIrq
);
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] statusQ;
  logic [NUM_LINES-1:0] statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wdata;
  end

  generate
    if (MODE == MODE_EDGE) begin : g_edge
      logic [NUM_LINES-1:0] prevIn;
      logic [NUM_LINES-1:0] clrOnes;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevIn <= '0;
        else prevIn <= irqIn;
      end
      always_comb begin
        clrOnes    = strobe.statWr ? wdata : '0;
        statusNext = (statusQ & ~clrOnes) | (irqIn & ~prevIn);
      end
      for (genvar b = 0; b < NUM_LINES; b++) begin : g_bit
        p_edge_set_r5: assert property (@(posedge clk) disable iff (!rstN)
          (irqIn[b] && !prevIn[b]) |=> statusQ[b]);
        p_edge_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
          $fell(statusQ[b]) |-> $past(strobe.statWr && wdata[b]));
      end
    end else if (MODE == MODE_LEGACY) begin : g_legacy
      logic [NUM_LINES-1:0] keepBits;
      always_comb begin
        keepBits   = strobe.statWr ? wdata : '1;
        statusNext = (statusQ & keepBits) | irqIn;
      end
      for (genvar b = 0; b < NUM_LINES; b++) begin : g_bit
        p_legacy_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
          irqIn[b] |=> statusQ[b]);
        p_legacy_w0c_r9: assert property (@(posedge clk) disable iff (!rstN)
          $fell(statusQ[b]) |-> $past(strobe.statWr && !wdata[b]));
      end
    end else begin : g_level
      always_comb statusNext = irqIn;
      p_level_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (statusQ == $past(irqIn)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      coreIrq <= 1'b0;
    end else begin
      statusQ <= statusNext;
      coreIrq <= |(statusQ & maskQ);
    end
  end

  always_comb begin
    if (strobe.rdMask)      rdata = maskQ;
    else if (strobe.rdStat) rdata = statusQ;
    else                    rdata = '0;
  end

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskWr |=> $stable(maskQ));
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !coreIrq);
endmodule

// File: rtl/core_irq_pic.sv
module core_irq_pic
  import pic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 2,
  parameter statModeE    MODE      = MODE_EDGE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 coreIrq
);
  picStrobeT strobe;

  pic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .strobe (strobe)
  );

  pic_datapath #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .strobe (strobe),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .coreIrq(coreIrq)
  );
endmodule

// File: tb/core_irq_pic_test.sv
module core_irq_pic_test;
  import pic_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  we = '0;
  logic [31:0] inE = '0, inG = '0, inV = '0;
  logic [31:0] rdE, rdG, rdV;
  logic        irqE, irqG, irqV;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  core_irq_pic #(.MODE(MODE_EDGE)) uut (
    .clk(clk), .rstN(rstN), .irqIn(inE), .regAddr(addr), .regWe(we[0]),
    .regWdata(wdata), .regRdata(rdE), .coreIrq(irqE));
  core_irq_pic #(.MODE(MODE_LEGACY)) uutLegacy (
    .clk(clk), .rstN(rstN), .irqIn(inG), .regAddr(addr), .regWe(we[1]),
    .regWdata(wdata), .regRdata(rdG), .coreIrq(irqG));
  core_irq_pic #(.MODE(MODE_LEVEL)) uutLevel (
    .clk(clk), .rstN(rstN), .irqIn(inV), .regAddr(addr), .regWe(we[2]),
    .regWdata(wdata), .regRdata(rdV), .coreIrq(irqV));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [1:0] a, input logic [31:0] d);
    addr = a;
    wdata = d;
    we[sel] = 1'b1;
    step();
    we = '0;
  endtask

  task automatic rd(input int sel, input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = (sel == 0) ? rdE : (sel == 1) ? rdG : rdV;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    for (int s = 0; s < 3; s++) begin
      rd(s, 2'd0, v); check("R1 mask", v, 32'h0);
      rd(s, 2'd1, v); check("R1 status", v, 32'h0);
    end
    check("R1 irq", {29'd0, irqE, irqG, irqV}, 32'h0);
  endtask

  task automatic test_mask_rw();
    logic [31:0] v;
    wr(0, 2'd0, 32'hA5A5_0F0F);
    rd(0, 2'd0, v); check("R2 readback", v, 32'hA5A5_0F0F);
    wr(0, 2'd0, 32'h0);
    rd(0, 2'd0, v); check("R2 cleared", v, 32'h0);
  endtask

  task automatic test_edge();
    logic [31:0] v;
    inE = 32'h8;
    step();
    rd(0, 2'd1, v); check("R5 edge latched", v, 32'h8);
    check("R3 masked quiet", {31'd0, irqE}, 32'h0);
    rd(0, 2'd1, v); check("R4 raw status with zero mask", v, 32'h8);
    rd(0, 2'd2, v); check("R4 unused address", v, 32'h0);
    wr(0, 2'd0, 32'h8);
    check("R3 not yet", {31'd0, irqE}, 32'h0);
    step();
    check("R3 raised", {31'd0, irqE}, 32'h1);
    wr(0, 2'd1, 32'h0);
    rd(0, 2'd1, v); check("R6 zero write no effect", v, 32'h8);
    wr(0, 2'd1, 32'h8);
    rd(0, 2'd1, v); check("R6 one write clears", v, 32'h0);
    step();
    check("R3 dropped", {31'd0, irqE}, 32'h0);
    step();
    rd(0, 2'd1, v); check("R5 steady high no retrigger", v, 32'h0);
  endtask

  task automatic test_edge_collision();
    logic [31:0] v;
    inE = 32'h0;
    step();
    inE = 32'h8;
    wr(0, 2'd1, 32'h8);
    rd(0, 2'd1, v); check("R7 set wins", v, 32'h8);
    inE = 32'h0;
    wr(0, 2'd1, 32'hFFFF_FFFF);
    wr(0, 2'd0, 32'h0);
  endtask

  task automatic test_legacy();
    logic [31:0] v;
    inG = 32'h1;
    step();
    inG = 32'h0;
    step();
    rd(1, 2'd1, v); check("R8 level latched", v, 32'h1);
    wr(1, 2'd1, 32'hFFFF_FFFF);
    rd(1, 2'd1, v); check("R9 one write no effect", v, 32'h1);
    wr(1, 2'd1, 32'h0);
    rd(1, 2'd1, v); check("R9 zero write clears", v, 32'h0);
    inG = 32'h2;
    step();
    wr(1, 2'd1, 32'h0);
    rd(1, 2'd1, v); check("R9 high input survives clear", v, 32'h2);
    inG = 32'h0;
    wr(1, 2'd1, 32'h0);
    rd(1, 2'd1, v); check("R9 cleared after drop", v, 32'h0);
  endtask

  task automatic test_level();
    logic [31:0] v;
    inV = 32'h30;
    step();
    rd(2, 2'd1, v); check("R10 follows input", v, 32'h30);
    wr(2, 2'd1, 32'h0);
    rd(2, 2'd1, v); check("R10 write ignored", v, 32'h30);
    wr(2, 2'd0, 32'h10);
    step();
    check("R3 level irq", {31'd0, irqV}, 32'h1);
    inV = 32'h20;
    step();
    rd(2, 2'd1, v); check("R10 tracks fall", v, 32'h20);
    step();
    check("R3 level irq drop", {31'd0, irqV}, 32'h0);
    rd(2, 2'd3, v); check("R4 address 3", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_mask_rw();
    test_edge();
    test_edge_collision();
    test_legacy();
    test_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule